// File: doc/BRIEF.md
# Posted-Write Queue with Read-Miss Forwarding

This block sits between a first-level cache and the next level of the memory hierarchy. The cache runs in write-through, no-allocate mode, so every store is posted into this queue, whether it hit the cache or missed it. The processor moves on as soon as the queue takes the write. The queue then retires its entries to the next level in arrival order, over a valid/ready handshake that runs on its own, whatever the processor is doing.

A read that hits in the cache never looks at the queue. A read that misses asks the queue first. Its word address is compared in parallel against every entry still waiting. If any entry matches, the queue returns that entry's data in the same cycle. This stops the read from fetching a stale word from the next level before an older write to the same address has landed. When several pending entries share the address, the most recently accepted one wins.

Top module: `wrbuf_fwd_top`

## Requirements
- R1: After reset the queue holds nothing: `wrReady` is 1, `nxValid` is 0, and a lookup reports no hit.
- R2: `wrReady` is 1 whenever fewer than DEPTH (default 4) entries are pending. It is 0 when DEPTH entries are pending, even in a cycle where one of them drains. A write is taken in every cycle where `wrValid` and `wrReady` are both 1.
- R3: `nxValid` is 1 whenever at least one entry is pending. `nxAddr`/`nxData` always show the oldest pending entry, so writes leave in exactly the order they were accepted.
- R4: While `nxValid` is 1 and `nxReady` is 0, `nxAddr` and `nxData` stay unchanged.
- R5: An entry leaves in a cycle where `nxValid` and `nxReady` are both 1. An accept and a drain in the same cycle both take effect.
- R6: When `lkValid` is 1 and `lkAddr` equals the address of a pending entry, `lkHit` is 1 in that same cycle and `lkData` carries that entry's data. The path is combinational.
- R7: When several pending entries match the lookup address, `lkData` comes from the one accepted last.
- R8: When `lkValid` is 0, or no pending entry matches, `lkHit` is 0 and `lkData` is 0.
- R9: An entry that drains in the same cycle as a matching lookup still counts as a match for that lookup. A write accepted in the same cycle as a lookup is not visible to it until the following cycle.
- R10: Lookups change neither the contents nor the order of the pending entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Processor offers a write |
| wrReady | output | 1 | Queue has room for a write |
| wrAddr | input | AW | Word address of the offered write |
| wrData | input | DW | Data word of the offered write |
| lkValid | input | 1 | Read-miss lookup request |
| lkAddr | input | AW | Word address of the read miss |
| lkHit | output | 1 | A pending entry matches the lookup |
| lkData | output | DW | Data of the youngest matching entry |
| nxValid | output | 1 | Oldest entry offered to the next level |
| nxReady | input | 1 | Next level takes the offered entry |
| nxAddr | output | AW | Address of the oldest entry |
| nxData | output | DW | Data of the oldest entry |

## Verification
A lookup can land in the same cycle as the drain of the very entry it matches, and also in the same cycle as the accept of a write to the same address. The bench provokes the first case by raising `nxReady` on the same edge that presents a lookup for the head address. It provokes the second by offering a write and a lookup for one fresh address together while the queue is empty. The scoreboard judges both cases: it holds the pending list as it stood before the current edge, so the draining head still counts as a match and the incoming write does not. A long stream of overlapping accepts, drains and lookups, with a gated `nxReady`, then checks order and forwarding together.

// File: rtl/wrbuf_pkg.sv
`timescale 1ns/1ps
package wrbuf_pkg;
  // Strobes issued by the control unit to the storage datapath each cycle
  typedef struct packed {
    logic push;  // write the offered word into the tail slot
    logic pop;   // retire the head slot
  } wbStrobes_t;
endpackage

// File: rtl/wrbuf_ctrl.sv
`timescale 1ns/1ps
module wrbuf_ctrl
  import wrbuf_pkg::*;
#(
  parameter int DEPTH = 4,               // power of two, at least 2
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrValid,
  output logic          wrReady,
  output logic          nxValid,
  input  logic          nxReady,
  output wbStrobes_t    strobes,
  output logic [PW-1:0] headIdx,
  output logic [PW-1:0] tailIdx,
  output logic [CW-1:0] usedCnt
);
  logic [PW-1:0] headQ, tailQ;
  logic [CW-1:0] usedQ;

  assign wrReady      = (usedQ != CW'(DEPTH));
  assign nxValid      = (usedQ != '0);
  assign strobes.push = wrValid && wrReady;
  assign strobes.pop  = nxValid && nxReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ <= '0;
      tailQ <= '0;
      usedQ <= '0;
    end else begin
      if (strobes.push) tailQ <= tailQ + PW'(1);
      if (strobes.pop)  headQ <= headQ + PW'(1);
      case ({strobes.push, strobes.pop})
        2'b10:   usedQ <= usedQ + CW'(1);
        2'b01:   usedQ <= usedQ - CW'(1);
        default: usedQ <= usedQ;
      endcase
    end
  end

  assign headIdx = headQ;
  assign tailIdx = tailQ;
  assign usedCnt = usedQ;

  // R2: occupancy never exceeds the queue depth
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    usedQ <= CW'(DEPTH));

  // R4: an offered entry stays offered until the next level takes it
  assert_hold_valid_R4: assert property (@(posedge clk) disable iff (!rstN)
    (nxValid && !nxReady) |=> nxValid);
endmodule

// File: rtl/wrbuf_data.sv
`timescale 1ns/1ps
module wrbuf_data
  import wrbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  wbStrobes_t    strobes,
  input  logic [PW-1:0] headIdx,
  input  logic [PW-1:0] tailIdx,
  input  logic [CW-1:0] usedCnt,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          lkValid,
  input  logic [AW-1:0] lkAddr,
  output logic          lkHit,
  output logic [DW-1:0] lkData,
  output logic [AW-1:0] nxAddr,
  output logic [DW-1:0] nxData
);
  logic [AW-1:0] addrQ [DEPTH];
  logic [DW-1:0] dataQ [DEPTH];
  logic [DEPTH-1:0] matchVec;

  always_ff @(posedge clk) begin
    if (strobes.push) begin
      addrQ[tailIdx] <= wrAddr;
      dataQ[tailIdx] <= wrData;
    end
  end

  assign nxAddr = addrQ[headIdx];
  assign nxData = dataQ[headIdx];

  // one comparator per slot; a slot is live when its age is below the occupancy
  for (genvar s = 0; s < DEPTH; s++) begin : gSlot
    logic [PW-1:0] slotAge;
    assign slotAge     = PW'(s) - headIdx;
    assign matchVec[s] = ({1'b0, slotAge} < {1'b0, usedCnt[CW-1:0]}) &&
                         (addrQ[s] == lkAddr);
  end

  // walk oldest to youngest, so the last match (youngest) wins
  always_comb begin
    lkHit  = 1'b0;
    lkData = '0;
    if (lkValid) begin
      for (int age = 0; age < DEPTH; age++) begin
        if (matchVec[headIdx + PW'(age)]) begin
          lkHit  = 1'b1;
          lkData = dataQ[headIdx + PW'(age)];
        end
      end
    end
  end

  // R8: no hit without a request
  assert_hit_needs_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> lkValid);

  // R6: an empty queue never forwards
  assert_empty_no_hit_R6: assert property (@(posedge clk) disable iff (!rstN)
    (usedCnt == '0) |-> !lkHit);
endmodule

// File: rtl/wrbuf_fwd_top.sv
`timescale 1ns/1ps
module wrbuf_fwd_top
  import wrbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrValid,
  output logic          wrReady,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          lkValid,
  input  logic [AW-1:0] lkAddr,
  output logic          lkHit,
  output logic [DW-1:0] lkData,
  output logic          nxValid,
  input  logic          nxReady,
  output logic [AW-1:0] nxAddr,
  output logic [DW-1:0] nxData
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  wbStrobes_t    strobes;
  logic [PW-1:0] headIdx, tailIdx;
  logic [CW-1:0] usedCnt;

  wrbuf_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrReady(wrReady),
    .nxValid(nxValid), .nxReady(nxReady), .strobes(strobes),
    .headIdx(headIdx), .tailIdx(tailIdx), .usedCnt(usedCnt)
  );

  wrbuf_data #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .headIdx(headIdx),
    .tailIdx(tailIdx), .usedCnt(usedCnt), .wrAddr(wrAddr), .wrData(wrData),
    .lkValid(lkValid), .lkAddr(lkAddr), .lkHit(lkHit), .lkData(lkData),
    .nxAddr(nxAddr), .nxData(nxData)
  );

  // R4: a stalled head word is held steady
  assert_hold_head_R4: assert property (@(posedge clk) disable iff (!rstN)
    (nxValid && !nxReady) |=> ($stable(nxAddr) && $stable(nxData)));

  // R5: an accept without a drain leaves something to offer
  assert_accept_grows_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrReady && !(nxValid && nxReady)) |=> nxValid);
endmodule

// File: tb/sim_wrbuf_fwd_top.sv
`timescale 1ns/1ps
module sim_wrbuf_fwd_top;
  localparam int DEPTH = 4;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0;
  logic wrValid = 1'b0, wrReady;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic lkValid = 1'b0, lkHit;
  logic [AW-1:0] lkAddr = '0;
  logic [DW-1:0] lkData;
  logic nxValid, nxReady = 1'b0;
  logic [AW-1:0] nxAddr;
  logic [DW-1:0] nxData;

  wrbuf_fwd_top #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrReady(wrReady),
    .wrAddr(wrAddr), .wrData(wrData), .lkValid(lkValid), .lkAddr(lkAddr),
    .lkHit(lkHit), .lkData(lkData), .nxValid(nxValid), .nxReady(nxReady),
    .nxAddr(nxAddr), .nxData(nxData)
  );

  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; } item_t;
  item_t sbQ[$];
  int nCmp = 0, nBad = 0, bothCnt = 0;
  bit done = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: compares the head against the scoreboard, then applies this edge
  always @(negedge clk) begin
    if (rstN) begin
      #2;
      chk("R2", "wrReady", {63'b0, wrReady}, {63'b0, sbQ.size() < DEPTH});
      chk("R3", "nxValid", {63'b0, nxValid}, {63'b0, sbQ.size() != 0});
      if (nxValid && sbQ.size() != 0) begin
        chk("R3", "nxAddr", 64'(nxAddr), 64'(sbQ[0].a));
        chk("R3", "nxData", 64'(nxData), 64'(sbQ[0].d));
      end
      if (nxValid && nxReady && wrValid && wrReady) bothCnt++;
      if (nxValid && nxReady && sbQ.size() != 0) void'(sbQ.pop_front());
      if (wrValid && wrReady) sbQ.push_back('{wrAddr, wrData});
    end
  end

  // driver: offer a write from a falling edge until accepted
  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wrValid = 1'b1; wrAddr = a; wrData = d;
    #1;
    while (!wrReady) begin @(negedge clk); #1; end
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  // lookup with expectation from the pending list before this edge
  task automatic lookCheck(input logic [AW-1:0] a, input string req);
    logic expHit;
    logic [DW-1:0] expData;
    lkValid = 1'b1; lkAddr = a;
    #1;
    expHit = 1'b0; expData = '0;
    foreach (sbQ[i]) if (sbQ[i].a == a) begin expHit = 1'b1; expData = sbQ[i].d; end
    chk(req, "lkHit", {63'b0, lkHit}, {63'b0, expHit});
    chk(req, "lkData", 64'(lkData), 64'(expData));
    @(negedge clk);
    lkValid = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] heldA;
    logic [DW-1:0] heldD;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: empty after reset
    #1;
    chk("R1", "wrReady", {63'b0, wrReady}, 64'd1);
    chk("R1", "nxValid", {63'b0, nxValid}, 64'd0);
    @(negedge clk);
    lookCheck(32'h0, "R1");

    // fill while the next level stalls
    doWrite(32'h104, 32'hB0B0_0001);
    doWrite(32'h100, 32'hA1A1_0001);
    doWrite(32'h108, 32'hC0C0_0003);
    doWrite(32'h100, 32'hA2A2_0002);
    wrValid = 1'b1; wrAddr = 32'h10C; wrData = 32'hD0D0_0004;
    #1;
    chk("R2", "full wrReady", {63'b0, wrReady}, 64'd0);
    heldA = nxAddr; heldD = nxData;
    @(negedge clk);
    lookCheck(32'h108, "R6");
    lookCheck(32'h100, "R7");
    lookCheck(32'h200, "R8");
    lkValid = 1'b0; lkAddr = 32'h104;
    #1;
    chk("R8", "idle lkHit", {63'b0, lkHit}, 64'd0);
    chk("R8", "idle lkData", 64'(lkData), 64'd0);
    @(negedge clk);
    // R4 / R10: head untouched by stalls and lookups
    chk("R4", "held nxAddr", 64'(nxAddr), 64'h104);
    chk("R10", "held nxData", 64'(nxData), 64'(heldD));
    chk("R4", "held vs first", 64'(nxAddr), 64'(heldA));

    // R9: lookup of the head in the cycle it drains
    nxReady = 1'b1;
    lookCheck(32'h104, "R9");
    doWrite(32'h10C, 32'hD0D0_0004);
    repeat (8) @(negedge clk);
    chk("R5", "drained empty", {63'b0, nxValid}, 64'd0);

    // R9: write and lookup of one address in the same cycle
    fork
      doWrite(32'h300, 32'hE0E0_0005);
      lookCheck(32'h300, "R9");
    join
    lookCheck(32'h300, "R9");
    repeat (3) @(negedge clk);

    // R5 / R6 / R10: overlapping stream with a gated drain
    fork
      for (int i = 0; i < 40; i++) doWrite(32'h400 + 32'(4 * (i % 8)), 32'h5000 + 32'(i));
      for (int k = 0; k < 90; k++) begin
        nxReady = (k % 3) != 0;
        @(negedge clk);
      end
      for (int j = 0; j < 60; j++) lookCheck(32'h400 + 32'(4 * (j % 10)), "R6");
    join
    nxReady = 1'b1;
    repeat (10) @(negedge clk);
    chk("R5", "overlap seen", {63'b0, bothCnt > 0}, 64'd1);
    chk("R10", "all drained", 64'(sbQ.size()), 64'd0);

    done = 1;
    summary();
    $finish;
  end
endmodule